// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core that uses overlapping register windows. The core names 32 architectural registers. The block maps each name onto physical storage through a current window pointer and an alternate-globals select. The storage is a flat array. It contains a normal global set, an alternate global set, and a ring of eight-register segments that the windows share. Within a window, the outgoing frame and the incoming frame sit in different segments, and each of those segments is also a frame of a neighbouring window. A value that one window leaves in its outgoing registers therefore shows up as the incoming registers of the next window. No data moves.

The core reads two operands combinationally, writes one result on each clock edge, and can clear the whole file in one cycle. A separate lookup port returns the flat physical index for any architectural index, so that trace and checkpoint logic can name the storage slot behind a register. An illegal window pointer is reported on an error output, and the last legal mapping stays in force.

Top module: `winreg_file`

## Requirements
- R1: Architectural index bits [4:3] pick the frame (0 = globals, 1 = outgoing, 2 = local, 3 = incoming). Bits [2:0] pick the register inside that frame.
- R2: For pointer value p, let b = ((6 − p) mod 6) × 2. The outgoing frame uses ring segment b, the local frame uses segment b+1, and the incoming frame uses segment (b+2) mod 12.
- R3: A value written to outgoing register k under pointer p reads back as incoming register k under pointer (p+1) mod 6, and this includes the wrap from 5 to 0.
- R4: With alt_glb = 1, indices 0–7 reach the alternate global set. With alt_glb = 0, they reach the normal set. The two sets keep separate values.
- R5: map_flat equals the frame offset ORed with index bits [2:0]. The offsets are 0 for the normal globals, 8 for the alternate globals, and 16 + 8 × segment for the windowed frames.
- R6: A clr cycle zeroes both global sets and all 12 segments. If clr and wr_en are both high, clr wins.
- R7: A pointer value of 6 or 7 drives cwp_err high in the same cycle. While the error is present, reads, writes and map_flat keep using the last legal pointer.
- R8: Normal global register 0 always reads as zero, and writes to it are dropped. Alternate global register 0 is an ordinary storage register.
- R9: Both read ports are combinational. A write becomes visible on the reads only after the clock edge that performs it.
- R10: A write lands in the slot selected by the pointer and alt_glb values present in its own cycle.
- R11: After reset every register reads zero, the held pointer is 0 and cwp_err is low for legal inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all storage |
| cwp | input | 3 | Current window pointer |
| alt_glb | input | 1 | Selects the alternate global set |
| rd_a_idx | input | 5 | Read port A architectural index |
| rd_a_data | output | 64 | Read port A data |
| rd_b_idx | input | 5 | Read port B architectural index |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write architectural index |
| wr_data | input | 64 | Write data |
| map_idx | input | 5 | Architectural index to translate |
| map_flat | output | 7 | Flat physical index of map_idx |
| cwp_err | output | 1 | Window pointer out of range |

## Verification
The assertions assume that cwp, alt_glb and every index are stable and known around each rising edge, and that reset is held for at least one edge before release. The bench changes all inputs only on falling edges and samples one time unit later. Each write is held for exactly one rising edge. Illegal pointer values are applied only after a legal pointer has been captured, so the held mapping is known when the error path is checked.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  localparam int unsigned FR_GLOBAL = 0;
  localparam int unsigned FR_OUTGO  = 1;
  localparam int unsigned FR_LOCAL  = 2;

  // Segment of the ring that a windowed frame occupies for pointer cwp.
  function automatic int unsigned ring_seg(input int unsigned frame,
                                           input int unsigned cwp,
                                           input int unsigned nwin);
    int unsigned base;
    base = ((nwin - cwp) % nwin) * 2;
    if (frame == FR_OUTGO)      return base;
    else if (frame == FR_LOCAL) return base + 1;
    else                        return (base + 2) % (2 * nwin);
  endfunction

  // Flat storage slot for an architectural index.
  function automatic int unsigned flat_of(input int unsigned idx,
                                          input int unsigned cwp,
                                          input bit          alt,
                                          input int unsigned nwin,
                                          input int unsigned fregs);
    int unsigned frame;
    int unsigned lo;
    frame = idx / fregs;
    lo    = idx % fregs;
    if (frame == FR_GLOBAL)
      return (alt ? fregs : 0) | lo;
    return ((2 + ring_seg(frame, cwp, nwin)) * fregs) | lo;
  endfunction

endpackage

// File: rtl/wrf_cwp_hold.sv
module wrf_cwp_hold #(
  parameter int unsigned NWIN  = 6,
  parameter int unsigned CWP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CWP_W-1:0] cwp_in,
  output logic [CWP_W-1:0] held_cwp,
  output logic [CWP_W-1:0] eff_cwp,
  output logic             cwp_bad
);

  assign cwp_bad = (32'(cwp_in) >= NWIN);
  assign eff_cwp = cwp_bad ? held_cwp : cwp_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_cwp <= '0;
    else if (!cwp_bad) held_cwp <= cwp_in;
  end

endmodule

// File: rtl/wrf_map.sv
module wrf_map #(
  parameter int unsigned NWIN       = 6,
  parameter int unsigned FRAME_REGS = 8,
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned CWP_W      = 3,
  parameter int unsigned FLAT_W     = 7
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [CWP_W-1:0]  cwp,
  input  logic              alt,
  output logic [FLAT_W-1:0] flat
);

  assign flat = FLAT_W'(wrf_pkg::flat_of(32'(idx), 32'(cwp), alt, NWIN, FRAME_REGS));

endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
  parameter int unsigned DEPTH  = 112,
  parameter int unsigned DATA_W = 64,
  parameter int unsigned FLAT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [FLAT_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [FLAT_W-1:0] raddr_a,
  input  logic [FLAT_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Slot 0 is the hardwired zero register: never written.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
    end else if (we && (waddr != '0) && (32'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = (32'(raddr_a) < DEPTH) ? mem[raddr_a] : '0;
  assign rdata_b = (32'(raddr_b) < DEPTH) ? mem[raddr_b] : '0;

endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int unsigned NWIN       = 6,
  parameter int unsigned FRAME_REGS = 8,
  parameter int unsigned DATA_W     = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic [2:0]  cwp,
  input  logic        alt_glb,
  input  logic [4:0]  rd_a_idx,
  output logic [63:0] rd_a_data,
  input  logic [4:0]  rd_b_idx,
  output logic [63:0] rd_b_data,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic [63:0] wr_data,
  input  logic [4:0]  map_idx,
  output logic [6:0]  map_flat,
  output logic        cwp_err
);

  localparam int unsigned IDX_W  = $clog2(FRAME_REGS) + 2;
  localparam int unsigned CWP_W  = $clog2(NWIN);
  localparam int unsigned DEPTH  = 2 * FRAME_REGS + 2 * NWIN * FRAME_REGS;
  localparam int unsigned FLAT_W = $clog2(DEPTH);
  localparam int unsigned NPORT  = 4;   // read A, read B, write, lookup

  logic [CWP_W-1:0]  held_cwp;
  logic [CWP_W-1:0]  eff_cwp;
  logic [IDX_W-1:0]  port_idx  [NPORT];
  logic [FLAT_W-1:0] port_flat [NPORT];
  logic [FLAT_W-1:0] wr_flat;
  logic              wr_fire;

  wrf_cwp_hold #(.NWIN(NWIN), .CWP_W(CWP_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .cwp_in(cwp),
    .held_cwp(held_cwp), .eff_cwp(eff_cwp), .cwp_bad(cwp_err)
  );

  assign port_idx[0] = rd_a_idx;
  assign port_idx[1] = rd_b_idx;
  assign port_idx[2] = wr_idx;
  assign port_idx[3] = map_idx;

  for (genvar g = 0; g < int'(NPORT); g++) begin : g_map
    wrf_map #(
      .NWIN(NWIN), .FRAME_REGS(FRAME_REGS), .IDX_W(IDX_W),
      .CWP_W(CWP_W), .FLAT_W(FLAT_W)
    ) u_map (
      .idx(port_idx[g]), .cwp(eff_cwp), .alt(alt_glb), .flat(port_flat[g])
    );
  end

  assign wr_flat  = port_flat[2];
  assign map_flat = port_flat[3];
  assign wr_fire  = wr_en && !clr && (wr_flat != '0);

  wrf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .FLAT_W(FLAT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .we(wr_en), .waddr(wr_flat), .wdata(wr_data),
    .raddr_a(port_flat[0]), .raddr_b(port_flat[1]),
    .rdata_a(rd_a_data), .rdata_b(rd_b_data)
  );

endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int unsigned NWIN   = 6,
  parameter int unsigned CWP_W  = 3,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned FLAT_W = 7,
  parameter int unsigned DEPTH  = 112,
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic [CWP_W-1:0]  cwp,
  input logic              alt_glb,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [DATA_W-1:0] rd_b_data,
  input logic [IDX_W-1:0]  map_idx,
  input logic [FLAT_W-1:0] map_flat,
  input logic              cwp_err,
  input logic [CWP_W-1:0]  held_cwp,
  input logic [CWP_W-1:0]  eff_cwp
);

  assert_held_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cwp_err |=> held_cwp == $past(cwp));

  assert_held_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cwp_err |=> $stable(held_cwp));

  assert_eff_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(eff_cwp) < NWIN);

  assert_zero_reg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0 && !alt_glb) |-> rd_a_data == '0);

  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (rd_a_data == '0 && rd_b_data == '0));

  assert_win_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (map_idx[IDX_W-1:IDX_W-2] != 2'b00) |-> (map_flat >= FLAT_W'(16) && 32'(map_flat) < DEPTH));

  assert_glb_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (map_idx[IDX_W-1:IDX_W-2] == 2'b00) |-> (map_flat[FLAT_W-1:4] == '0 && map_flat[3] == alt_glb));

endmodule

bind winreg_file wrf_checker #(
  .NWIN(NWIN), .CWP_W(CWP_W), .IDX_W(IDX_W),
  .FLAT_W(FLAT_W), .DEPTH(DEPTH), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .cwp(cwp), .alt_glb(alt_glb),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
  .map_idx(map_idx), .map_flat(map_flat), .cwp_err(cwp_err),
  .held_cwp(held_cwp), .eff_cwp(eff_cwp)
);

// File: tb/winreg_file_bench.sv
`timescale 1ns/1ps
module winreg_file_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [2:0]  cwp = '0;
  logic        alt_glb = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, map_idx = '0;
  logic [63:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic [63:0] rd_a_data, rd_b_data;
  logic [6:0]  map_flat;
  logic        cwp_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  winreg_file u_winreg_file (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cwp(cwp), .alt_glb(alt_glb),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .map_idx(map_idx), .map_flat(map_flat), .cwp_err(cwp_err)
  );

  // Expected slot: outgoing segment is (12 - 2p) mod 12, the others follow it on the ring.
  function automatic int exp_flat(input int idx, input int p, input bit alt);
    int fr, r, seg;
    fr = idx / 8;
    r  = idx % 8;
    if (fr == 0) return (alt ? 8 : 0) + r;
    seg = ((12 - 2 * p) % 12 + fr - 1) % 12;
    return 16 + seg * 8 + r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic set_ctx(input int p, input bit alt);
    @(negedge clk);
    cwp = 3'(p);
    alt_glb = alt;
  endtask

  task automatic do_wr(input int idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_a(input int idx, output logic [63:0] d);
    rd_a_idx = 5'(idx);
    #1;
    d = rd_a_data;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    set_ctx(0, 1'b0);
    rd_a(5, d);        chk("R11", "reg 5 after reset", d, 64'h0);
    rd_b_idx = 5'd20; #1; chk("R11", "reg 20 after reset", rd_b_data, 64'h0);
    chk("R11", "cwp_err after reset", {63'h0, cwp_err}, 64'h0);
    map_idx = 5'd8; #1; chk("R11", "flat of out0 at held 0", {57'h0, map_flat}, 64'd16);
  endtask

  task automatic t_flat_map;
    for (int p = 0; p < 6; p++) begin
      for (int a = 0; a < 2; a++) begin
        set_ctx(p, a[0]);
        for (int i = 0; i < 32; i++) begin
          map_idx = 5'(i);
          #0.01;
          chk("R5", $sformatf("flat idx %0d cwp %0d alt %0d", i, p, a),
              {57'h0, map_flat}, 64'(exp_flat(i, p, a[0])));
        end
      end
    end
    // frame decode spot checks (R1, R2)
    set_ctx(1, 1'b0);
    map_idx = 5'd24; #1; chk("R1", "in0 at cwp1 lands in segment 0", {57'h0, map_flat}, 64'd16);
    map_idx = 5'd9;  #1; chk("R2", "out1 at cwp1 lands in segment 10", {57'h0, map_flat}, 64'd97);
    set_ctx(2, 1'b0);
    map_idx = 5'd31; #1; chk("R2", "in7 at cwp2 lands in segment 10", {57'h0, map_flat}, 64'd103);
  endtask

  task automatic t_globals;
    logic [63:0] d;
    set_ctx(0, 1'b0); do_wr(3, 64'hA0A0_0000_0000_0003);
    set_ctx(0, 1'b1); do_wr(3, 64'hB0B0_0000_0000_0003);
    rd_a(3, d); chk("R4", "alt global 3", d, 64'hB0B0_0000_0000_0003);
    set_ctx(0, 1'b0);
    rd_a(3, d); chk("R4", "normal global 3", d, 64'hA0A0_0000_0000_0003);
    do_wr(0, 64'hDEAD_BEEF);
    rd_a(0, d); chk("R8", "normal global 0 stays zero", d, 64'h0);
    set_ctx(0, 1'b1);
    rd_a(0, d); chk("R8", "alt global 0 unaffected by dropped write", d, 64'h0);
    do_wr(0, 64'hC0C0_C0C0);
    rd_a(0, d); chk("R8", "alt global 0 is storage", d, 64'hC0C0_C0C0);
    set_ctx(0, 1'b0);
    rd_a(0, d); chk("R8", "normal global 0 after alt write", d, 64'h0);
  endtask

  task automatic t_overlap;
    logic [63:0] d;
    set_ctx(0, 1'b0);
    do_wr(10, 64'h0D0D_0000_0000_000A);
    do_wr(18, 64'h0E0E_0000_0000_0012);
    set_ctx(1, 1'b0);
    rd_a(26, d); chk("R3", "out2 at cwp0 seen as in2 at cwp1", d, 64'h0D0D_0000_0000_000A);
    rd_a(18, d); chk("R2", "local2 at cwp1 separate from cwp0", d, 64'h0);
    set_ctx(5, 1'b0);
    do_wr(12, 64'h0F0F_0000_0000_000C);
    set_ctx(0, 1'b0);
    rd_a(28, d); chk("R3", "wrap: out4 at cwp5 seen as in4 at cwp0", d, 64'h0F0F_0000_0000_000C);
    rd_a(18, d); chk("R3", "local2 at cwp0 unchanged by moves", d, 64'h0E0E_0000_0000_0012);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    cwp = 3'd2; alt_glb = 1'b0;
    wr_en = 1'b1; wr_idx = 5'd13; wr_data = 64'h1234_5678_9ABC_DEF0;
    rd_a_idx = 5'd13; rd_b_idx = 5'd13;
    #1;
    chk("R9", "read before write edge shows old", rd_a_data, 64'h0);
    @(posedge clk); #1;
    chk("R9", "read after write edge shows new", rd_b_data, 64'h1234_5678_9ABC_DEF0);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_write_ctx_and_err;
    logic [63:0] d;
    set_ctx(3, 1'b0);
    do_wr(9, 64'h4848_0000_0000_0009);
    set_ctx(4, 1'b0);
    rd_a(9, d);  chk("R10", "out1 at cwp4 differs from cwp3", d, 64'h0);
    rd_a(25, d); chk("R10", "in1 at cwp4 holds the cwp3 write", d, 64'h4848_0000_0000_0009);
    set_ctx(3, 1'b0);
    rd_a(9, d);  chk("R10", "out1 back at cwp3", d, 64'h4848_0000_0000_0009);
    @(negedge clk);
    cwp = 3'd7;
    #1;
    chk("R7", "cwp 7 flags error", {63'h0, cwp_err}, 64'h1);
    map_idx = 5'd9; #0.5;
    chk("R7", "map keeps cwp3", {57'h0, map_flat}, 64'(exp_flat(9, 3, 1'b0)));
    rd_a(9, d);  chk("R7", "read keeps cwp3", d, 64'h4848_0000_0000_0009);
    do_wr(17, 64'h7777_0000_0000_0011);
    @(negedge clk);
    cwp = 3'd6; #1;
    chk("R7", "cwp 6 flags error", {63'h0, cwp_err}, 64'h1);
    @(negedge clk);
    cwp = 3'd5; #1;
    chk("R7", "cwp 5 is legal", {63'h0, cwp_err}, 64'h0);
    set_ctx(3, 1'b0);
    rd_a(17, d); chk("R7", "write under bad cwp went to cwp3", d, 64'h7777_0000_0000_0011);
  endtask

  task automatic t_clear;
    logic [63:0] d;
    @(negedge clk);
    cwp = 3'd0; alt_glb = 1'b0;
    clr = 1'b1; wr_en = 1'b1; wr_idx = 5'd5; wr_data = 64'h5555;
    @(negedge clk);
    clr = 1'b0; wr_en = 1'b0;
    rd_a(5, d);  chk("R6", "clear beats write", d, 64'h0);
    rd_a(3, d);  chk("R6", "normal global cleared", d, 64'h0);
    rd_a(18, d); chk("R6", "local cleared", d, 64'h0);
    alt_glb = 1'b1;
    rd_a(0, d);  chk("R6", "alt global cleared", d, 64'h0);
    set_ctx(3, 1'b0);
    rd_a(9, d);  chk("R6", "window segment cleared", d, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_flat_map();
    t_globals();
    t_overlap();
    t_same_cycle();
    t_write_ctx_and_err();
    t_clear();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule